// File: doc/BRIEF.md
# Host Mailbox Transaction Sequencer

This block is the host side of a byte-wide command/data mailbox. It owns a small register bus with two ports, data and status/command, and runs one whole transaction at a time. A send takes a byte stream over valid/ready and pushes it into the mailbox with the required handshakes. A receive collects a response frame into an output byte stream and checks the length field that the frame carries.

Every handshake step is a poll: the status byte is read, masked and compared with an expected pattern. The step passes on the first read that matches. It fails when a per-step timeout expires. Each failure cause has its own error code. The sequencer always goes back to idle and reports completion with a one-cycle `done` pulse, an error code and a length value.

Top module: `mbx_seq`

## Requirements
- R1: Bus encoding is as follows. `bus_addr`=0 selects the data port and `bus_addr`=1 selects the status (read) / command (write) port. Status bits are OBF=bit0, IBF=bit1, F0=bit2, ready-for-command=bit4 and ready-for-data=bit5. A read is one cycle, and `bus_rdata` is taken in the cycle `bus_rd` is high. A write is one cycle. `bus_rd` and `bus_wr` are never high together.
- R2: The first bus operation of every send is a write of 0x22 (cancel) to the command port, in the cycle after the start is accepted.
- R3: A send then runs these steps in order: wait bit4=1, wait IBF=0, write 0x01 to the command port, wait bit5=1. For each stream byte it waits IBF=0, raises `tx_ready`, and writes the byte to the data port in the cycle after the handshake. After the byte flagged `tx_last` it waits IBF=0 once more and writes 0x03 to the command port. It then ends with code 0 and `resp_len` equal to the number of bytes sent.
- R4: During the ready-for-command wait, a status read that shows OBF=1 is followed by a data-port read, and bit4 of that data byte is tested in place of the status.
- R5: Each wait passes at the first matching read and otherwise times out. The ready-for-command wait allows TMO_SHORT compares and every other wait allows TMO_LONG. The timeout codes are: ready 1, IBF before normal 2, ready-for-data 3, IBF before a byte 4, IBF before end 5, F0 6, OBF 7.
- R6: A receive with `rx_limit` below 6 ends with code 12, with no bus access, two cycles after the start.
- R7: A receive waits for F0=1, then reads one data byte. If that byte is not 0x01, it ends with code 8.
- R8: After the start byte, each poll that ends with OBF=1 and F0=0 reads one data byte and puts it on `rx_data` with a one-cycle `rx_valid`, in arrival order. When OBF=1 and F0=1, the next data byte must be 0x03, or the receive ends with code 9.
- R9: The response length is the big-endian 32-bit value in payload bytes 2..5 (byte 2 most significant) and is reported on `resp_len`. If it exceeds `rx_limit`, the receive ends with code 11.
- R10: If `rx_limit` payload bytes arrive without F0, the receive ends with code 10 and no further bus access.
- R11: `done` is a single-cycle pulse. `busy` is high from the accepted start until `done`, and it is low again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_send | input | 1 | Begin a send transaction (taken when idle) |
| start_recv | input | 1 | Begin a receive transaction (taken when idle) |
| rx_limit | input | LEN_W | Caller buffer limit for a receive |
| tx_valid | input | 1 | Send stream byte valid |
| tx_data | input | 8 | Send stream byte |
| tx_last | input | 1 | Marks the final send byte |
| tx_ready | output | 1 | Sequencer accepts a send byte |
| rx_valid | output | 1 | Received payload byte valid |
| rx_data | output | 8 | Received payload byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 4 | Result code, 0 on success |
| resp_len | output | 32 | Bytes sent, or decoded response length |
| bus_rd | output | 1 | Mailbox read strobe |
| bus_wr | output | 1 | Mailbox write strobe |
| bus_addr | output | 1 | 0 data port, 1 status/command port |
| bus_wdata | output | 8 | Mailbox write data |
| bus_rdata | input | 8 | Mailbox read data, valid while bus_rd is high |

## Verification
The short-limit rejection has a fixed schedule, so `done` is checked exactly two cycles after the start, with no bus strobe before it. Other transactions depend on how fast the modelled mailbox answers. For these the bench waits for the `done` pulse, reads `err_code` and `resp_len` in that same cycle, and then confirms `done` is low and the sequencer idle one cycle later. The order and content of bus writes are logged each cycle and compared with the expected command sequence. Received bytes are captured on the cycles where `rx_valid` is high. A data write must appear one cycle after each stream handshake.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int B_OBF = 0;
  localparam int B_IBF = 1;
  localparam int B_F0  = 2;
  localparam int B_RDY = 4;
  localparam int B_IBR = 5;

  localparam logic [7:0] CMD_CANCEL = 8'h22;
  localparam logic [7:0] CMD_NORMAL = 8'h01;
  localparam logic [7:0] CMD_EOC    = 8'h03;

  localparam int MIN_LIMIT = 6;
  localparam int LEN_FIRST = 2;
  localparam int LEN_BYTES = 4;

  typedef enum logic [3:0] {
    E_OK        = 4'd0,
    E_TMO_RDY   = 4'd1,
    E_TMO_IBF0  = 4'd2,
    E_TMO_IBR   = 4'd3,
    E_TMO_IBFD  = 4'd4,
    E_TMO_IBFE  = 4'd5,
    E_TMO_F0    = 4'd6,
    E_TMO_OBF   = 4'd7,
    E_BAD_START = 4'd8,
    E_BAD_END   = 4'd9,
    E_NO_F0     = 4'd10,
    E_LEN_OVER  = 4'd11,
    E_LIMIT     = 4'd12
  } err_e;

  typedef struct packed {
    logic [7:0] mask;
    logic [7:0] val;
    logic       long_t;
    logic       rdy_sub;
  } poll_req_t;

  localparam poll_req_t REQ_RDY     = '{mask: 8'h10, val: 8'h10, long_t: 1'b0, rdy_sub: 1'b1};
  localparam poll_req_t REQ_IBF_CLR = '{mask: 8'h02, val: 8'h00, long_t: 1'b1, rdy_sub: 1'b0};
  localparam poll_req_t REQ_IBR     = '{mask: 8'h20, val: 8'h20, long_t: 1'b1, rdy_sub: 1'b0};
  localparam poll_req_t REQ_F0      = '{mask: 8'h04, val: 8'h04, long_t: 1'b1, rdy_sub: 1'b0};
  localparam poll_req_t REQ_OBF     = '{mask: 8'h01, val: 8'h01, long_t: 1'b1, rdy_sub: 1'b0};

endpackage

// File: rtl/mbx_poll.sv
module mbx_poll
  import mbx_pkg::*;
#(
  parameter int TMO_SHORT = 20,
  parameter int TMO_LONG  = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  poll_req_t  req,
  output logic       rd,
  output logic       addr,
  input  logic [7:0] rdata,
  output logic       hit,
  output logic       hit_f0,
  output logic       tmo
);

  localparam int CW = $clog2(TMO_LONG + 1);

  typedef enum logic [1:0] {PI, PS, PD} pst_e;

  pst_e            ps;
  poll_req_t       req_q;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lim_m1;
  logic            sub;
  logic            match;

  assign lim_m1 = req_q.long_t ? CW'(TMO_LONG - 1) : CW'(TMO_SHORT - 1);

  always_comb begin
    sub   = (ps == PS) && req_q.rdy_sub && rdata[B_OBF];
    match = (rdata & req_q.mask) == req_q.val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps     <= PI;
      req_q  <= '0;
      cnt    <= '0;
      rd     <= 1'b0;
      addr   <= 1'b1;
      hit    <= 1'b0;
      hit_f0 <= 1'b0;
      tmo    <= 1'b0;
    end else begin
      hit <= 1'b0;
      tmo <= 1'b0;
      case (ps)
        PI: begin
          if (go) begin
            req_q <= req;
            cnt   <= '0;
            rd    <= 1'b1;
            addr  <= 1'b1;
            ps    <= PS;
          end
        end
        PS, PD: begin
          if (sub) begin
            addr <= 1'b0;
            ps   <= PD;
          end else if (match) begin
            hit    <= 1'b1;
            hit_f0 <= rdata[B_F0];
            rd     <= 1'b0;
            ps     <= PI;
          end else if (cnt == lim_m1) begin
            tmo <= 1'b1;
            rd  <= 1'b0;
            ps  <= PI;
          end else begin
            cnt  <= cnt + 1'b1;
            addr <= 1'b1;
            ps   <= PS;
          end
        end
        default: ps <= PI;
      endcase
    end
  end

  // R5: a wait ends either matched or expired, never both
  p_hit_tmo_excl_r5: assert property (@(posedge clk) disable iff (rst) !(hit && tmo));
  // R5: the compare count stays inside the selected window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst) (ps != PI) |-> (cnt <= lim_m1));
  // R5: a match is only reported after a read was on the bus
  p_hit_after_read_r5: assert property (@(posedge clk) disable iff (rst) hit |-> $past(rd));

endmodule

// File: rtl/mbx_len_cap.sv
module mbx_len_cap
  import mbx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [LEN_W-1:0] idx,
  input  logic [7:0]       din,
  output logic [31:0]      len
);

  logic in_win;

  assign in_win = (idx >= LEN_W'(LEN_FIRST)) && (idx < LEN_W'(LEN_FIRST + LEN_BYTES));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len <= '0;
    end else if (push && in_win) begin
      len <= {len[23:0], din};
    end
  end

  // R9: each byte of the length window lands in the low byte, older bytes move up
  p_len_shift_r9: assert property (@(posedge clk) disable iff (rst)
    (push && in_win && !clr) |=> (len[7:0] == $past(din)));

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int TMO_SHORT = 20,
  parameter int TMO_LONG  = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_send,
  input  logic             start_recv,
  input  logic [LEN_W-1:0] rx_limit,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  input  logic             tx_last,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             done,
  output logic [3:0]       err_code,
  output logic [31:0]      resp_len,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata
);

  typedef enum logic [4:0] {
    S_IDLE, S_CANCEL, S_W_RDY, S_W_IBF0, S_NORMAL, S_W_IBR, S_W_IBFD,
    S_TXACC, S_TXWR, S_W_IBFE, S_EOC, S_W_F0, S_RDSTART, S_W_OBF,
    S_RDBYTE, S_RDEND, S_DONE
  } st_e;

  st_e              st;
  err_e             err_q;
  logic             is_rx;
  logic             last_q;
  logic [LEN_W-1:0] lim_q;
  logic [LEN_W-1:0] tcnt;
  logic [LEN_W-1:0] rcnt;
  logic [LEN_W-1:0] rcnt_nx;
  logic             fsm_rd, fsm_wr, fsm_addr;
  logic [7:0]       fsm_wdata;
  logic             p_go, p_rd, p_addr, p_hit, p_hit_f0, p_tmo;
  poll_req_t        preq;
  logic [31:0]      cap_len;
  logic             cap_clr;
  logic             cap_push;
  logic             short_lim;

  assign rcnt_nx   = rcnt + 1'b1;
  assign short_lim = rx_limit < LEN_W'(MIN_LIMIT);
  assign cap_clr   = (st == S_IDLE) && !start_send && start_recv;
  assign cap_push  = (st == S_RDBYTE);

  mbx_poll #(.TMO_SHORT(TMO_SHORT), .TMO_LONG(TMO_LONG)) u_poll (
    .clk    (clk),
    .rst    (rst),
    .go     (p_go),
    .req    (preq),
    .rd     (p_rd),
    .addr   (p_addr),
    .rdata  (bus_rdata),
    .hit    (p_hit),
    .hit_f0 (p_hit_f0),
    .tmo    (p_tmo)
  );

  mbx_len_cap #(.LEN_W(LEN_W)) u_len (
    .clk  (clk),
    .rst  (rst),
    .clr  (cap_clr),
    .push (cap_push),
    .idx  (rcnt),
    .din  (bus_rdata),
    .len  (cap_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      err_q     <= E_OK;
      is_rx     <= 1'b0;
      last_q    <= 1'b0;
      lim_q     <= '0;
      tcnt      <= '0;
      rcnt      <= '0;
      fsm_rd    <= 1'b0;
      fsm_wr    <= 1'b0;
      fsm_addr  <= 1'b0;
      fsm_wdata <= '0;
      p_go      <= 1'b0;
      preq      <= '0;
      done      <= 1'b0;
      err_code  <= '0;
      resp_len  <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      fsm_rd   <= 1'b0;
      fsm_wr   <= 1'b0;
      p_go     <= 1'b0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_send) begin
            is_rx     <= 1'b0;
            tcnt      <= '0;
            fsm_wr    <= 1'b1;
            fsm_addr  <= 1'b1;
            fsm_wdata <= CMD_CANCEL;
            st        <= S_CANCEL;
          end else if (start_recv) begin
            is_rx <= 1'b1;
            lim_q <= rx_limit;
            rcnt  <= '0;
            if (short_lim) begin
              err_q <= E_LIMIT;
              st    <= S_DONE;
            end else begin
              p_go <= 1'b1;
              preq <= REQ_F0;
              st   <= S_W_F0;
            end
          end
        end
        S_CANCEL: begin
          p_go <= 1'b1;
          preq <= REQ_RDY;
          st   <= S_W_RDY;
        end
        S_W_RDY: begin
          if (p_hit) begin
            p_go <= 1'b1;
            preq <= REQ_IBF_CLR;
            st   <= S_W_IBF0;
          end else if (p_tmo) begin
            err_q <= E_TMO_RDY;
            st    <= S_DONE;
          end
        end
        S_W_IBF0: begin
          if (p_hit) begin
            fsm_wr    <= 1'b1;
            fsm_addr  <= 1'b1;
            fsm_wdata <= CMD_NORMAL;
            st        <= S_NORMAL;
          end else if (p_tmo) begin
            err_q <= E_TMO_IBF0;
            st    <= S_DONE;
          end
        end
        S_NORMAL: begin
          p_go <= 1'b1;
          preq <= REQ_IBR;
          st   <= S_W_IBR;
        end
        S_W_IBR: begin
          if (p_hit) begin
            p_go <= 1'b1;
            preq <= REQ_IBF_CLR;
            st   <= S_W_IBFD;
          end else if (p_tmo) begin
            err_q <= E_TMO_IBR;
            st    <= S_DONE;
          end
        end
        S_W_IBFD: begin
          if (p_hit) begin
            st <= S_TXACC;
          end else if (p_tmo) begin
            err_q <= E_TMO_IBFD;
            st    <= S_DONE;
          end
        end
        S_TXACC: begin
          if (tx_valid) begin
            fsm_wr    <= 1'b1;
            fsm_addr  <= 1'b0;
            fsm_wdata <= tx_data;
            tcnt      <= tcnt + 1'b1;
            last_q    <= tx_last;
            st        <= S_TXWR;
          end
        end
        S_TXWR: begin
          p_go <= 1'b1;
          preq <= REQ_IBF_CLR;
          st   <= last_q ? S_W_IBFE : S_W_IBFD;
        end
        S_W_IBFE: begin
          if (p_hit) begin
            fsm_wr    <= 1'b1;
            fsm_addr  <= 1'b1;
            fsm_wdata <= CMD_EOC;
            st        <= S_EOC;
          end else if (p_tmo) begin
            err_q <= E_TMO_IBFE;
            st    <= S_DONE;
          end
        end
        S_EOC: begin
          err_q <= E_OK;
          st    <= S_DONE;
        end
        S_W_F0: begin
          if (p_hit) begin
            fsm_rd   <= 1'b1;
            fsm_addr <= 1'b0;
            st       <= S_RDSTART;
          end else if (p_tmo) begin
            err_q <= E_TMO_F0;
            st    <= S_DONE;
          end
        end
        S_RDSTART: begin
          if (bus_rdata != CMD_NORMAL) begin
            err_q <= E_BAD_START;
            st    <= S_DONE;
          end else begin
            p_go <= 1'b1;
            preq <= REQ_OBF;
            st   <= S_W_OBF;
          end
        end
        S_W_OBF: begin
          if (p_hit) begin
            fsm_rd   <= 1'b1;
            fsm_addr <= 1'b0;
            st       <= p_hit_f0 ? S_RDEND : S_RDBYTE;
          end else if (p_tmo) begin
            err_q <= E_TMO_OBF;
            st    <= S_DONE;
          end
        end
        S_RDBYTE: begin
          rx_valid <= 1'b1;
          rx_data  <= bus_rdata;
          rcnt     <= rcnt_nx;
          if (rcnt_nx == lim_q) begin
            err_q <= E_NO_F0;
            st    <= S_DONE;
          end else begin
            p_go <= 1'b1;
            preq <= REQ_OBF;
            st   <= S_W_OBF;
          end
        end
        S_RDEND: begin
          if (bus_rdata != CMD_EOC) begin
            err_q <= E_BAD_END;
          end else if (cap_len > {{(32-LEN_W){1'b0}}, lim_q}) begin
            err_q <= E_LEN_OVER;
          end else begin
            err_q <= E_OK;
          end
          st <= S_DONE;
        end
        S_DONE: begin
          done     <= 1'b1;
          err_code <= err_q;
          resp_len <= is_rx ? cap_len : {{(32-LEN_W){1'b0}}, tcnt};
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tx_ready  = (st == S_TXACC);
  assign busy      = (st != S_IDLE);
  assign bus_rd    = fsm_rd | p_rd;
  assign bus_addr  = p_rd ? p_addr : fsm_addr;
  assign bus_wr    = fsm_wr;
  assign bus_wdata = fsm_wdata;

  // R1: reads and writes never share a cycle
  p_no_rw_clash_r1: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr));
  // R2: an accepted send opens with the cancel command
  p_cancel_first_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start_send) |=> (bus_wr && bus_addr && bus_wdata == CMD_CANCEL));
  // R3: each accepted stream byte goes to the data port on the next cycle
  p_tx_write_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (bus_wr && !bus_addr && bus_wdata == $past(tx_data)));
  // R6: a too-small limit is refused without any bus access
  p_short_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start_send && start_recv && short_lim)
      |=> (!bus_rd && !bus_wr) ##1 (done && err_code == E_LIMIT));
  // R9: a successful receive never reports a length above its limit
  p_len_ok_r9: assert property (@(posedge clk) disable iff (rst)
    (done && is_rx && err_code == E_OK) |-> (resp_len <= {{(32-LEN_W){1'b0}}, lim_q}));
  // R11: completion is a single pulse followed by idle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst) done |=> (!done && !busy));

endmodule

// File: tb/tb_mbx_seq.sv
module tb_mbx_seq;
  localparam int LEN_W = 16;
  localparam int TS    = 20;
  localparam int TL    = 2000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_send = 1'b0, start_recv = 1'b0;
  logic [LEN_W-1:0] rx_limit = '0;
  logic             tx_valid = 1'b0, tx_last = 1'b0;
  logic [7:0]       tx_data = '0;
  logic             tx_ready, rx_valid, busy, done;
  logic [7:0]       rx_data;
  logic [3:0]       err_code;
  logic [31:0]      resp_len;
  logic             bus_rd, bus_wr, bus_addr;
  logic [7:0]       bus_wdata, bus_rdata;

  int nchk = 0, nfail = 0, cyc = 0;

  // mailbox model
  logic [7:0] q_b [64];
  logic       q_f [64];
  int         q_n = 0;
  int         q_i = 0;
  int         ibf_cnt = 0;
  logic       dev_clr = 1'b0;
  logic [7:0] st_extra = 8'h00;
  logic [7:0] dev_stat;
  logic       q_has;

  // logs
  logic [8:0] wlog [64];
  int         wn = 0;
  logic [7:0] rxb [64];
  int         rxn = 0;

  always #5 clk = ~clk;

  mbx_seq #(.LEN_W(LEN_W), .TMO_SHORT(TS), .TMO_LONG(TL)) dut (
    .clk(clk), .rst(rst), .start_send(start_send), .start_recv(start_recv),
    .rx_limit(rx_limit), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .done(done), .err_code(err_code), .resp_len(resp_len), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  assign q_has     = (q_i < q_n);
  assign dev_stat  = st_extra | {5'b0, q_has && q_f[q_i[5:0]], ibf_cnt != 0, q_has};
  assign bus_rdata = bus_addr ? dev_stat : (q_has ? q_b[q_i[5:0]] : 8'hFF);

  always @(posedge clk) begin
    if (dev_clr) begin
      q_i     <= 0;
      ibf_cnt <= 0;
    end else begin
      if (bus_rd && !bus_addr && q_has) q_i <= q_i + 1;
      if (bus_wr && !bus_addr) ibf_cnt <= 3;
      else if (ibf_cnt != 0) ibf_cnt <= ibf_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (bus_wr && wn < 64) begin
      wlog[wn] <= {bus_addr, bus_wdata};
      wn <= wn + 1;
    end
    if (rx_valid && rxn < 64) begin
      rxb[rxn] <= rx_data;
      rxn <= rxn + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dev_load(input logic [7:0] extra);
    st_extra = extra;
    q_n = 0;
    dev_clr = 1'b1;
    @(negedge clk);
    dev_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic q_push(input logic [7:0] b, input logic f);
    q_b[q_n] = b;
    q_f[q_n] = f;
    q_n++;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R11 done seen", {31'b0, done}, 32'd1);
  endtask

  task automatic after_done();
    @(negedge clk);
    check("R11 done single pulse", {31'b0, done}, 32'd0);
    check("R11 idle after done", {31'b0, busy}, 32'd0);
  endtask

  task automatic drive_tx(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      tx_valid = 1'b1;
      tx_data  = base + 8'(i);
      tx_last  = (i == n - 1);
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
    end
    tx_valid = 1'b0;
    tx_last  = 1'b0;
  endtask

  task automatic start_tx();
    wn = 0;
    start_send = 1'b1;
    @(negedge clk);
    start_send = 1'b0;
  endtask

  task automatic start_rx(input int lim);
    rxn = 0;
    rx_limit = LEN_W'(lim);
    start_recv = 1'b1;
    @(negedge clk);
    start_recv = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset busy", {31'b0, busy}, 32'd0);
    check("R11 reset done", {31'b0, done}, 32'd0);
    check("R3 reset tx_ready", {31'b0, tx_ready}, 32'd0);
    check("R1 reset bus idle", {30'b0, bus_rd, bus_wr}, 32'd0);
  endtask

  task automatic t_send_ok();
    dev_load(8'h30);
    start_tx();
    fork
      drive_tx(3, 8'hA0);
      wait_done();
    join
    check("R3 send code", {28'b0, err_code}, 32'd0);
    check("R3 send count", resp_len, 32'd3);
    after_done();
    check("R3 write count", wn, 32'd6);
    check("R2 cancel first", {23'b0, wlog[0]}, 32'h122);
    check("R3 normal write", {23'b0, wlog[1]}, 32'h101);
    for (int i = 0; i < 3; i++)
      check("R3 data write", {23'b0, wlog[2+i]}, {23'b0, 1'b0, 8'hA0 + 8'(i)});
    check("R3 end write", {23'b0, wlog[5]}, 32'h103);
  endtask

  task automatic t_send_rdy_via_data();
    dev_load(8'h20);
    q_push(8'h10, 1'b0);
    start_tx();
    fork
      drive_tx(1, 8'h55);
      wait_done();
    join
    check("R4 send via data port code", {28'b0, err_code}, 32'd0);
    check("R4 data port consumed", q_i, 32'd1);
    after_done();
  endtask

  task automatic t_send_rdy_tmo();
    dev_load(8'h00);
    start_tx();
    wait_done();
    check("R5 ready timeout code", {28'b0, err_code}, 32'd1);
    after_done();
    check("R5 only cancel written", wn, 32'd1);
  endtask

  task automatic t_send_ibr_tmo();
    dev_load(8'h10);
    start_tx();
    wait_done();
    check("R5 ready-for-data timeout code", {28'b0, err_code}, 32'd3);
    after_done();
    check("R5 no data written", wn, 32'd2);
  endtask

  task automatic t_recv_short();
    logic seen;
    dev_load(8'h00);
    wn = 0;
    rx_limit = LEN_W'(5);
    start_recv = 1'b1;
    @(negedge clk);
    start_recv = 1'b0;
    seen = bus_rd | bus_wr;
    @(negedge clk);
    seen = seen | bus_rd | bus_wr;
    check("R6 no bus access", {31'b0, seen}, 32'd0);
    check("R6 done at second cycle", {31'b0, done}, 32'd1);
    check("R6 limit code", {28'b0, err_code}, 32'd12);
    after_done();
  endtask

  task automatic t_recv_ok();
    logic [7:0] pl [10];
    pl = '{8'hAA, 8'hBB, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h11, 8'h22, 8'h33, 8'h44};
    dev_load(8'h00);
    q_push(8'h01, 1'b1);
    for (int i = 0; i < 10; i++) q_push(pl[i], 1'b0);
    q_push(8'h03, 1'b1);
    start_rx(16);
    wait_done();
    check("R8 recv ok code", {28'b0, err_code}, 32'd0);
    check("R9 big-endian length", resp_len, 32'd10);
    after_done();
    check("R8 byte count", rxn, 32'd10);
    for (int i = 0; i < 10; i++) check("R8 byte order", {24'b0, rxb[i]}, {24'b0, pl[i]});
  endtask

  task automatic t_recv_bad_start();
    dev_load(8'h00);
    q_push(8'h02, 1'b1);
    start_rx(16);
    wait_done();
    check("R7 bad start code", {28'b0, err_code}, 32'd8);
    after_done();
  endtask

  task automatic t_recv_bad_end();
    dev_load(8'h00);
    q_push(8'h01, 1'b1);
    for (int i = 0; i < 6; i++) q_push(8'h00, 1'b0);
    q_push(8'h04, 1'b1);
    start_rx(16);
    wait_done();
    check("R8 bad end code", {28'b0, err_code}, 32'd9);
    after_done();
  endtask

  task automatic t_recv_len_over();
    dev_load(8'h00);
    q_push(8'h01, 1'b1);
    q_push(8'h00, 1'b0); q_push(8'h00, 1'b0);
    q_push(8'h00, 1'b0); q_push(8'h00, 1'b0);
    q_push(8'h01, 1'b0); q_push(8'h00, 1'b0);
    q_push(8'h03, 1'b1);
    start_rx(16);
    wait_done();
    check("R9 length overflow code", {28'b0, err_code}, 32'd11);
    check("R9 reported length", resp_len, 32'h100);
    after_done();
  endtask

  task automatic t_recv_no_f0();
    dev_load(8'h00);
    q_push(8'h01, 1'b1);
    for (int i = 0; i < 8; i++) q_push(8'(i + 1), 1'b0);
    start_rx(6);
    wait_done();
    check("R10 missing F0 code", {28'b0, err_code}, 32'd10);
    after_done();
    check("R10 stops at limit", rxn, 32'd6);
    check("R10 no extra data read", q_i, 32'd7);
  endtask

  task automatic t_recv_f0_tmo();
    dev_load(8'h00);
    start_rx(16);
    wait_done();
    check("R5 F0 timeout code", {28'b0, err_code}, 32'd6);
    after_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_send_ok();
    t_send_rdy_via_data();
    t_send_rdy_tmo();
    t_send_ibr_tmo();
    t_recv_short();
    t_recv_ok();
    t_recv_bad_start();
    t_recv_bad_end();
    t_recv_len_over();
    t_recv_no_f0();
    t_recv_f0_tmo();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule